// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a 32-bit interval timer for a processor's exception logic. A counter advances by one on every tick strobe and wraps modulo 2^32. A limit register holds a target value. When an increment brings the counter onto the limit, a sticky timer interrupt is raised. The interrupt stays up until software writes the limit register again, which is also how software re-arms the timer for the next interval.

Software reaches the timer through a plain register port. A write takes effect at the next clock edge, and a read returns the current value combinationally. Each address selects a register: 0 is the counter, 1 is the limit, 2 is the control word and 3 is the read-only status word. The control word holds a freeze bit that stops counting and a 3-bit field that routes the interrupt to one of eight output lines. The parameter `KEEP_STATUS` decides at build time whether a status flag that software can read is kept beside the line.

No path in this block carries a data stream, so there is no valid/ready handshake. A register write is accepted in the cycle it is presented and cannot be held off, and every pin is a plain level or strobe.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter, the limit and the control word all read 0, and all eight interrupt lines are low.
- R2: With the freeze bit clear and no counter write, each cycle with `tick_i` high adds one to the counter. The value 0xFFFFFFFF wraps to 0. Cycles without a tick leave the counter unchanged.
- R3: While control bit 0 (freeze) is 1, ticks do not change the counter. After freeze is cleared, counting resumes from the held value.
- R4: A write to address 0 loads the counter at the next edge. The load wins over a tick in the same cycle, and it also works while frozen.
- R5: When an increment moves the counter onto the limit value, the selected interrupt line rises at the same edge that updates the counter. The line stays high while the counter moves past the limit.
- R6: Loading the counter with a value equal to the limit through a write does not raise the interrupt.
- R7: A write to address 1 clears the interrupt and the status flag at the next edge. In a cycle that has both a limit write and a matching increment, the clear wins.
- R8: Control bits 3:1 select the line index 0..7. Output `irq_o[k]` is high only when the interrupt is pending and the index is k, so at most one line is high. Changing the index moves a pending interrupt to the new line at once.
- R9: With `KEEP_STATUS`=1, bit 0 at address 3 reads 1 exactly while the interrupt is pending. With `KEEP_STATUS`=0 it always reads 0, and the line still works.
- R10: Address 2 reads back the freeze bit in bit 0 and the route field in bits 3:1, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time-base strobe that advances the counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 counter, 1 limit, 2 control) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address (0..3) |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 8 | Routed timer interrupt lines |

## Verification
Two pairs of functions can fall in the same cycle. A counter write can coincide with a tick, and a limit write can coincide with an increment that lands on the old limit. The bench raises `tick_i` in the same cycle as each write. In the first case it checks that the counter holds the written value and not an incremented one. In the second it checks that the line stays low even though the counter now equals the old limit. Two builds, with and without the status flag, receive the same stimulus, and the status readback of each is judged against its own rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_LIMIT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int FREEZE_BIT = 0;
  localparam int ROUTE_LSB  = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         adv_en,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_inc_o
);
  logic [W-1:0] cnt_q;

  assign cnt_inc_o = cnt_q + W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= load_val;
    else if (adv_en)  cnt_q <= cnt_inc_o;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W           = 32,
  parameter bit KEEP_STATUS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] cnt_inc,
  input  logic [W-1:0] limit,
  input  logic         clr,
  output logic         irq_o,
  output logic         sts_o
);
  logic hit;
  logic irq_q;

  assign hit   = step && (cnt_inc == limit);
  assign irq_o = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (clr) irq_q <= 1'b0;
    else if (hit) irq_q <= 1'b1;
  end

  generate
    if (KEEP_STATUS) begin : g_sts
      logic sts_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sts_q <= 1'b0;
        else if (clr) sts_q <= 1'b0;
        else if (hit) sts_q <= 1'b1;
      end
      assign sts_o = sts_q;
    end else begin : g_nosts
      assign sts_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tmr_router.sv
module tmr_router #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic          irq,
  input  logic [RW-1:0] sel,
  output logic [N-1:0]  lines
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_line
      assign lines[g] = irq && (sel == RW'(g));
    end
  endgenerate
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W       = 32,
  parameter int N_LINES     = 8,
  parameter bit KEEP_STATUS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic [N_LINES-1:0] irq_o
);
  import tmr_pkg::*;

  localparam int ROUTE_W = $clog2(N_LINES);
  localparam int ROUTE_MSB = ROUTE_LSB + ROUTE_W - 1;

  logic               cnt_wr, lim_wr, ctl_wr;
  logic               step;
  logic [CNT_W-1:0]   cnt_q, cnt_inc;
  logic [CNT_W-1:0]   limit_q;
  logic               freeze_q;
  logic [ROUTE_W-1:0] route_q;
  logic               irq_q, sts;

  assign cnt_wr = wr_en_i && (wr_addr_i == REG_COUNT);
  assign lim_wr = wr_en_i && (wr_addr_i == REG_LIMIT);
  assign ctl_wr = wr_en_i && (wr_addr_i == REG_CTRL);
  assign step   = tick_i && !freeze_q && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= '0;
      freeze_q <= 1'b0;
      route_q  <= '0;
    end else begin
      if (lim_wr) limit_q <= wr_data_i;
      if (ctl_wr) begin
        freeze_q <= wr_data_i[FREEZE_BIT];
        route_q  <= wr_data_i[ROUTE_MSB:ROUTE_LSB];
      end
    end
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cnt_wr),
    .load_val (wr_data_i),
    .adv_en   (tick_i && !freeze_q),
    .cnt_o    (cnt_q),
    .cnt_inc_o(cnt_inc)
  );

  tmr_match #(.W(CNT_W), .KEEP_STATUS(KEEP_STATUS)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .cnt_inc(cnt_inc),
    .limit  (limit_q),
    .clr    (lim_wr),
    .irq_o  (irq_q),
    .sts_o  (sts)
  );

  tmr_router #(.N(N_LINES), .RW(ROUTE_W)) u_route (
    .irq  (irq_q),
    .sel  (route_q),
    .lines(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_COUNT: rd_data_o = cnt_q;
      REG_LIMIT: rd_data_o = limit_q;
      REG_CTRL: begin
        rd_data_o[FREEZE_BIT]          = freeze_q;
        rd_data_o[ROUTE_MSB:ROUTE_LSB] = route_q;
      end
      default:   rd_data_o[0] = sts;
    endcase
  end
endmodule

module tmr_chk #(
  parameter int CNT_W   = 32,
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_addr_i,
  input logic [CNT_W-1:0]   wr_data_i,
  input logic [N_LINES-1:0] irq_o,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               freeze_q,
  input logic               irq_q,
  input logic               sts
);
  logic cw, lw;
  assign cw = wr_en_i && (wr_addr_i == 2'd0);
  assign lw = wr_en_i && (wr_addr_i == 2'd1);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_q && !cw && (cnt_q == '1)) |=> (cnt_q == '0));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !cw) |=> $stable(cnt_q));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (cnt_q == $past(wr_data_i)));

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !lw) |=> irq_q);

  // R7
  limit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw |=> (irq_o == '0));

  // R8
  line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  // R8
  line_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (irq_o != '0));

  // R9
  sts_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts |-> irq_q);
endmodule

bind interval_timer tmr_chk #(.CNT_W(CNT_W), .N_LINES(N_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .irq_o    (irq_o),
  .cnt_q    (cnt_q),
  .freeze_q (freeze_q),
  .irq_q    (irq_q),
  .sts      (sts)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_a, rd_b;
  logic [7:0]  irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  int pending = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  interval_timer #(.KEEP_STATUS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_a), .irq_o(irq_a));

  interval_timer #(.KEEP_STATUS(1'b0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_b), .irq_o(irq_b));

  typedef struct {
    int          dsel;
    bit          is_line;
    logic [1:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  // monitor: pops expected items and compares with what the design shows
  initial begin
    item_t it;
    logic [31:0] got;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      if (!it.is_line) rd_addr = it.addr;
      #1;
      if (it.is_line) got = (it.dsel == 0) ? {24'h0, irq_a} : {24'h0, irq_b};
      else            got = (it.dsel == 0) ? rd_a : rd_b;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
      pending--;
    end
  end

  task automatic push(input int d, input bit ln, input logic [1:0] a,
                      input logic [31:0] e, input string tag);
    item_t it;
    it.dsel = d; it.is_line = ln; it.addr = a; it.exp = e; it.tag = tag;
    pending++;
    sb.push_back(it);
    wait (pending == 0);
  endtask

  task automatic chk_reg(input int d, input logic [1:0] a,
                         input logic [31:0] e, input string tag);
    push(d, 1'b0, a, e, tag);
  endtask

  task automatic chk_line(input logic [7:0] e, input string tag);
    push(0, 1'b1, 2'd0, {24'h0, e}, tag);
    push(1, 1'b1, 2'd0, {24'h0, e}, tag);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk_reg(0, 2'd0, 32'h0, "R1 count");
    chk_reg(0, 2'd1, 32'h0, "R1 limit");
    chk_reg(0, 2'd2, 32'h0, "R1 ctrl");
    chk_line(8'h00, "R1 lines");

    // R2 plain counting
    tick_n(5);
    chk_reg(0, 2'd0, 32'd5, "R2 five ticks");
    cyc(); cyc();
    chk_reg(0, 2'd0, 32'd5, "R2 idle holds");

    // R5 match and stickiness, R9 status
    wr(2'd1, 32'd8);
    tick_n(2);
    chk_line(8'h00, "R5 before match");
    tick_n(1);
    chk_reg(0, 2'd0, 32'd8, "R5 count at match");
    chk_line(8'h01, "R5 line on match");
    chk_reg(0, 2'd3, 32'd1, "R9 status kept");
    chk_reg(1, 2'd3, 32'd0, "R9 status absent");
    tick_n(3);
    chk_line(8'h01, "R5 sticky past limit");

    // R7 limit write clears
    wr(2'd1, 32'd100);
    chk_line(8'h00, "R7 clear on limit write");
    chk_reg(0, 2'd3, 32'd0, "R7 status cleared");

    // R10, R8 routing
    wr(2'd2, 32'h0000_000A);
    chk_reg(0, 2'd2, 32'h0000_000A, "R10 ctrl readback");
    wr(2'd0, 32'd98);
    chk_reg(0, 2'd0, 32'd98, "R4 count load");
    tick_n(2);
    chk_line(8'h20, "R8 route 5");
    wr(2'd2, 32'h0000_0004);
    chk_line(8'h04, "R8 route moved to 2");

    // R3 freeze, R4 load while frozen
    wr(2'd2, 32'h0000_0005);
    tick_n(4);
    chk_reg(0, 2'd0, 32'd100, "R3 frozen holds");
    wr(2'd0, 32'd500);
    chk_reg(0, 2'd0, 32'd500, "R4 load while frozen");
    wr(2'd2, 32'h0000_0004);
    tick_n(1);
    chk_reg(0, 2'd0, 32'd501, "R3 resume");

    // R4 load beats tick in the same cycle
    tick = 1'b1;
    wr(2'd0, 32'd7);
    tick = 1'b0;
    chk_reg(0, 2'd0, 32'd7, "R4 load over tick");

    // R6 load equal to limit does not raise
    wr(2'd1, 32'd20);
    chk_line(8'h00, "R7 clear again");
    wr(2'd0, 32'd20);
    chk_reg(0, 2'd0, 32'd20, "R6 count loaded");
    chk_line(8'h00, "R6 no irq on load");

    // R7 limit write wins over simultaneous match
    wr(2'd0, 32'd29);
    wr(2'd1, 32'd30);
    tick = 1'b1;
    wr(2'd1, 32'd50);
    tick = 1'b0;
    chk_reg(0, 2'd0, 32'd30, "R7 count advanced");
    chk_reg(0, 2'd1, 32'd50, "R7 new limit");
    chk_line(8'h00, "R7 clear wins");
    wr(2'd0, 32'd49);
    tick_n(1);
    chk_line(8'h04, "R5 match on new limit");

    // R2 wrap and match at zero
    wr(2'd1, 32'd0);
    chk_line(8'h00, "R7 clear before wrap");
    wr(2'd0, 32'hFFFF_FFFF);
    tick_n(1);
    chk_reg(0, 2'd0, 32'd0, "R2 wrap to zero");
    chk_line(8'h04, "R5 match after wrap");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule